// File: doc/BRIEF.md
# Half-Pel Search Result Byte Serializer

This block receives nine 16-bit error values measured at a 3x3 half-pixel neighbourhood around a centre motion vector. On a start pulse it captures all nine values and a mode flag. It finds the smallest value and converts the winning position into a 4-bit direction code. It then sends the result out as a stream of bytes over a valid/ready handshake.

There are two modes. In the short mode only the minimum and the code are sent. In the long mode all nine measured values follow them. Every 16-bit quantity is split into two bytes, with the upper byte sent first. The last flag marks the final byte. One cycle after the final byte is accepted, a one-cycle done pulse appears and the block is idle again.

The input vector `eval_vals` holds position k in bits `[16k+15:16k]`. Positions are numbered 0 centre, 1 upper-left, 2 up, 3 upper-right, 4 left, 5 right, 6 lower-left, 7 down, 8 lower-right. A horizontal offset of -0.5 pixel is left and a vertical offset of -0.5 pixel is up.

Top module: `dp_result_serializer`

## Requirements
- R1: A start pulse seen while idle captures `eval_vals` and `frame_mode`. At the next clock edge `busy` and `out_valid` go high, presenting byte 0.
- R2: With `frame_mode` low, exactly three bytes are sent: minimum upper byte, minimum lower byte, direction byte.
- R3: With `frame_mode` high, exactly 21 bytes are sent. The first three are as in R2. Then two bytes follow for each of positions 0 to 8, in that position order.
- R4: Every 16-bit value is unsigned and is sent as bits [15:8] first, then bits [7:0].
- R5: The direction byte carries bit 3 = up, bit 2 = down, bit 1 = left and bit 0 = right, so 0000 means the centre. Its bits [7:4] are zero.
- R6: The reported minimum is the smallest of the nine values. On a tie the lowest position number wins, which puts the centre first.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values.
- R8: `out_last` is high only together with `out_valid`, and only on the final byte of the sequence.
- R9: `done` is high for exactly the one cycle after the final byte is accepted. In that cycle `out_valid` and `busy` are already low.
- R10: Changes on `eval_vals`, `frame_mode` or `start` while `busy` is high do not alter the sequence being sent.
- R11: After reset, `out_valid`, `done` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a sequence; honoured only while idle |
| frame_mode | input | 1 | 1 = 21-byte sequence, 0 = 3-byte sequence |
| eval_vals | input | 144 | Nine 16-bit error values, position k at bits [16k+15:16k] |
| out_ready | input | 1 | Sink accepts the current byte |
| out_data | output | 8 | Current byte |
| out_valid | output | 1 | `out_data` is valid |
| out_last | output | 1 | Current byte is the final one |
| done | output | 1 | One-cycle pulse after the final byte is accepted |
| busy | output | 1 | A sequence is in progress |

## Verification
Assertions check on every cycle:
- that a stalled byte holds;
- that the last flag comes only with valid and only at the mode's final index;
- that done is a single-cycle pulse following the final handshake;
- that the captured operands stay frozen while busy;
- that the reported minimum bounds all nine values and beats every earlier position strictly.

Only the bench scenarios can show that the bytes leave in the right order with the right values. They also show the exact direction code for each of the nine winners, and the tie outcomes when equal minima sit at several positions. The bench sweeps every winner position in both modes and under several backpressure patterns.

// File: rtl/dp_ser_pkg.sv
package dp_ser_pkg;

  localparam int NPOS      = 9;
  localparam int FIELD_LEN = 3;
  localparam int FRAME_LEN = 3 + 2 * NPOS;
  localparam int CODE_W    = 4;

  typedef enum logic [3:0] {
    P_CTR = 4'd0,
    P_UL  = 4'd1,
    P_UP  = 4'd2,
    P_UR  = 4'd3,
    P_LF  = 4'd4,
    P_RT  = 4'd5,
    P_LL  = 4'd6,
    P_DN  = 4'd7,
    P_LR  = 4'd8
  } pos_e;

  localparam logic [CODE_W-1:0] DIR_UP = 4'b1000;
  localparam logic [CODE_W-1:0] DIR_DN = 4'b0100;
  localparam logic [CODE_W-1:0] DIR_LF = 4'b0010;
  localparam logic [CODE_W-1:0] DIR_RT = 4'b0001;

  // Direction bitmask for a neighbourhood position.
  function automatic logic [CODE_W-1:0] dir_code(input logic [3:0] pos);
    logic [CODE_W-1:0] c;
    c = '0;
    case (pos)
      P_UL:    c = DIR_UP | DIR_LF;
      P_UP:    c = DIR_UP;
      P_UR:    c = DIR_UP | DIR_RT;
      P_LF:    c = DIR_LF;
      P_RT:    c = DIR_RT;
      P_LL:    c = DIR_DN | DIR_LF;
      P_DN:    c = DIR_DN;
      P_LR:    c = DIR_DN | DIR_RT;
      default: c = '0;
    endcase
    return c;
  endfunction

  // Index of the final byte for a mode.
  function automatic int unsigned last_index(input logic frame);
    return frame ? FRAME_LEN - 1 : FIELD_LEN - 1;
  endfunction

endpackage

// File: rtl/dp_min_finder.sv
module dp_min_finder #(
  parameter int VAL_W = 16,
  parameter int NPOS  = 9,
  parameter int IDX_W = 4
) (
  input  logic [NPOS*VAL_W-1:0] vals,
  output logic [VAL_W-1:0]      min_val,
  output logic [IDX_W-1:0]      min_idx
);

  // Linear chain: a later position replaces the running best only when
  // strictly smaller, so ties resolve to the lowest position number.
  logic [VAL_W-1:0] best_v [NPOS];
  logic [IDX_W-1:0] best_i [NPOS];

  assign best_v[0] = vals[VAL_W-1:0];
  assign best_i[0] = '0;

  for (genvar k = 1; k < NPOS; k++) begin : g_stage
    logic [VAL_W-1:0] cand;
    logic             take;
    assign cand      = vals[k*VAL_W +: VAL_W];
    assign take      = cand < best_v[k-1];
    assign best_v[k] = take ? cand : best_v[k-1];
    assign best_i[k] = take ? IDX_W'(k) : best_i[k-1];
  end

  assign min_val = best_v[NPOS-1];
  assign min_idx = best_i[NPOS-1];

endmodule

// File: rtl/dp_byte_sel.sv
module dp_byte_sel #(
  parameter int VAL_W  = 16,
  parameter int BYTE_W = 8,
  parameter int NPOS   = 9,
  parameter int SEQ_W  = 5
) (
  input  logic [NPOS*VAL_W-1:0] vals,
  input  logic [VAL_W-1:0]      min_val,
  input  logic [3:0]            code,
  input  logic [SEQ_W-1:0]      idx,
  output logic [BYTE_W-1:0]     byte_o
);

  localparam int HDR = 3;

  function automatic logic [BYTE_W-1:0] hi_part(input logic [VAL_W-1:0] v);
    return v[VAL_W-1 -: BYTE_W];
  endfunction

  function automatic logic [BYTE_W-1:0] lo_part(input logic [VAL_W-1:0] v);
    return v[BYTE_W-1:0];
  endfunction

  logic [SEQ_W-1:0] rel;
  logic [SEQ_W-1:0] pos;
  logic [VAL_W-1:0] sel_v;

  always_comb begin
    rel   = idx - SEQ_W'(HDR);
    pos   = rel >> 1;
    sel_v = '0;
    if (int'(pos) < NPOS) sel_v = vals[int'(pos)*VAL_W +: VAL_W];
    case (idx)
      SEQ_W'(0): byte_o = hi_part(min_val);
      SEQ_W'(1): byte_o = lo_part(min_val);
      SEQ_W'(2): byte_o = {{(BYTE_W-4){1'b0}}, code};
      default:   byte_o = rel[0] ? lo_part(sel_v) : hi_part(sel_v);
    endcase
  end

endmodule

// File: rtl/dp_ser_ctrl.sv
module dp_ser_ctrl
  import dp_ser_pkg::*;
#(
  parameter int SEQ_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_q,
  input  logic             out_ready,
  output logic             load,
  output logic             busy,
  output logic             out_valid,
  output logic             out_last,
  output logic [SEQ_W-1:0] idx,
  output logic             hs,
  output logic             final_hs,
  output logic             done
);

  typedef enum logic {S_IDLE, S_SEND} st_e;
  st_e st;

  logic [SEQ_W-1:0] last_idx;

  assign last_idx  = SEQ_W'(last_index(mode_q));
  assign busy      = (st == S_SEND);
  assign out_valid = busy;
  assign out_last  = busy && (idx == last_idx);
  assign load      = start && !busy;
  assign hs        = out_valid && out_ready;
  assign final_hs  = hs && out_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      idx  <= '0;
      done <= 1'b0;
    end else begin
      done <= final_hs;
      if (load) begin
        st  <= S_SEND;
        idx <= '0;
      end else if (final_hs) begin
        st  <= S_IDLE;
        idx <= '0;
      end else if (hs) begin
        idx <= idx + 1'b1;
      end
    end
  end

  a_r1_load_presents: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid && idx == '0);
  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(idx));
  a_r8_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  a_r9_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    final_hs |=> done && !out_valid);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(final_hs));

endmodule

// File: rtl/dp_result_serializer.sv
module dp_result_serializer
  import dp_ser_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      frame_mode,
  input  logic [NPOS*2*BYTE_W-1:0]  eval_vals,
  input  logic                      out_ready,
  output logic [BYTE_W-1:0]         out_data,
  output logic                      out_valid,
  output logic                      out_last,
  output logic                      done,
  output logic                      busy
);

  localparam int VAL_W = 2 * BYTE_W;
  localparam int IDX_W = $clog2(NPOS);
  localparam int SEQ_W = $clog2(FRAME_LEN);

  logic [NPOS*VAL_W-1:0] vals_q;
  logic                  mode_q;
  logic                  load;
  logic                  hs;
  logic                  final_hs;
  logic [SEQ_W-1:0]      idx;
  logic [VAL_W-1:0]      min_val;
  logic [IDX_W-1:0]      min_idx;
  logic [3:0]            code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vals_q <= '0;
      mode_q <= 1'b0;
    end else if (load) begin
      vals_q <= eval_vals;
      mode_q <= frame_mode;
    end
  end

  dp_ser_ctrl #(.SEQ_W(SEQ_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode_q    (mode_q),
    .out_ready (out_ready),
    .load      (load),
    .busy      (busy),
    .out_valid (out_valid),
    .out_last  (out_last),
    .idx       (idx),
    .hs        (hs),
    .final_hs  (final_hs),
    .done      (done)
  );

  dp_min_finder #(.VAL_W(VAL_W), .NPOS(NPOS), .IDX_W(IDX_W)) u_min (
    .vals    (vals_q),
    .min_val (min_val),
    .min_idx (min_idx)
  );

  assign code = dir_code(4'(min_idx));

  dp_byte_sel #(.VAL_W(VAL_W), .BYTE_W(BYTE_W), .NPOS(NPOS), .SEQ_W(SEQ_W)) u_sel (
    .vals    (vals_q),
    .min_val (min_val),
    .code    (code),
    .idx     (idx),
    .byte_o  (out_data)
  );

  // Operands are frozen for the whole sequence.
  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(vals_q) && $stable(mode_q));
  a_r7_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_data) && $stable(out_last));
  a_r5_code_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && idx == SEQ_W'(2) |-> out_data[BYTE_W-1:4] == '0);
  a_r2_field_length: assert property (@(posedge clk) disable iff (!rst_n)
    out_last && !mode_q |-> idx == SEQ_W'(FIELD_LEN - 1));
  a_r3_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
    out_last && mode_q |-> idx == SEQ_W'(FRAME_LEN - 1));

  for (genvar k = 0; k < NPOS; k++) begin : g_min_chk
    a_r6_min_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> min_val <= vals_q[k*VAL_W +: VAL_W]);
    a_r6_earliest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      busy && (IDX_W'(k) < min_idx) |-> vals_q[k*VAL_W +: VAL_W] > min_val);
  end

endmodule

// File: tb/dp_result_serializer_tb.sv
module dp_result_serializer_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         frame_mode = 1'b0;
  logic [143:0] eval_vals = '0;
  logic         out_ready = 1'b0;
  logic [7:0]   out_data;
  logic         out_valid, out_last, done, busy;

  int checks = 0;
  int errors = 0;
  logic [15:0] v [9];

  always #4 clk = ~clk;  // 125 MHz

  dp_result_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_mode(frame_mode),
    .eval_vals(eval_vals), .out_ready(out_ready), .out_data(out_data),
    .out_valid(out_valid), .out_last(out_last), .done(done), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected code from grid offsets: position 0 is the centre; the rest
  // walk the 3x3 raster skipping the centre cell.
  function automatic logic [3:0] exp_code(input int p);
    int r, dx, dy;
    if (p == 0) return 4'b0000;
    r  = p - 1;
    if (r >= 4) r = r + 1;
    dx = r % 3 - 1;
    dy = r / 3 - 1;
    return {dy < 0, dy > 0, dx < 0, dx > 0};
  endfunction

  task automatic run(input bit mode, input int stall);
    logic [7:0] exp_b [21];
    int len, mi, n, cyc, run_err;
    bit prev_stall, rdy;
    logic [7:0] prev_data;
    logic prev_last;
    mi = 0;
    for (int k = 1; k < 9; k++) if (v[k] < v[mi]) mi = k;
    exp_b[0] = v[mi][15:8];
    exp_b[1] = v[mi][7:0];
    exp_b[2] = {4'b0000, exp_code(mi)};
    for (int k = 0; k < 9; k++) begin
      exp_b[3 + 2*k] = v[k][15:8];
      exp_b[4 + 2*k] = v[k][7:0];
    end
    len = mode ? 21 : 3;
    for (int k = 0; k < 9; k++) eval_vals[16*k +: 16] = v[k];
    frame_mode = mode;
    run_err = errors;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(out_valid && busy, "R1 valid/busy after start", {out_valid, busy}, 2'b11);
    // R10: disturb every input while the sequence runs
    eval_vals = ~eval_vals;
    frame_mode = ~mode;
    start = 1'b1;
    n = 0; cyc = 0; prev_stall = 0; prev_data = '0; prev_last = 0;
    while (n < len && cyc < 2000) begin
      chk(out_valid, "R8 valid during sequence", out_valid, 1);
      if (prev_stall) chk(out_data == prev_data && out_last == prev_last,
                          "R7 stalled byte holds", out_data, prev_data);
      rdy = (stall == 0) ? 1'b1 : ((cyc % (stall + 1)) == stall);
      out_ready = rdy;
      if (rdy) begin
        if (!mode)      chk(out_data == exp_b[n], "R2 field byte", out_data, exp_b[n]);
        else if (n < 2) chk(out_data == exp_b[n], "R6 minimum byte", out_data, exp_b[n]);
        else if (n == 2) chk(out_data == exp_b[n], "R5 direction byte", out_data, exp_b[n]);
        else            chk(out_data == exp_b[n], "R4 value byte", out_data, exp_b[n]);
        chk(out_last == (n == len - 1), "R8 last flag", out_last, n == len - 1);
        n++;
      end
      prev_stall = !rdy;
      prev_data = out_data;
      prev_last = out_last;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    out_ready = 1'b0;
    if (mode) chk(n == 21, "R3 frame length", n, 21);
    chk(done && !out_valid && !busy, "R9 done after final", {done, out_valid, busy}, 3'b100);
    @(negedge clk);
    chk(!done && !busy && !out_valid, "R9 done single cycle", {done, busy, out_valid}, 0);
    chk(errors == run_err, "R10 sequence unaffected by inputs", errors - run_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && !done && !busy, "R11 reset state", {out_valid, done, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !busy, "R11 idle after reset", {out_valid, busy}, 0);
    for (int m = 0; m < 2; m++) begin
      for (int w = 0; w < 9; w++) begin
        for (int k = 0; k < 9; k++) v[k] = 16'h1000 + 16'(k * 16'h0111) ^ 16'(w);
        v[w] = 16'(w * 16'h0101);
        run(m[0], w % 3);
      end
      // R6 ties: all equal at maximum -> centre
      for (int k = 0; k < 9; k++) v[k] = 16'hFFFF;
      run(m[0], 1);
      // R6 tie between left and down -> left
      for (int k = 0; k < 9; k++) v[k] = 16'h9000;
      v[4] = 16'h0005; v[7] = 16'h0005;
      run(m[0], 2);
      // R6 tie between right and lower-right at zero -> right
      for (int k = 0; k < 9; k++) v[k] = 16'h00FF;
      v[5] = 16'h0000; v[8] = 16'h0000;
      run(m[0], 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule